// File: doc/BRIEF.md
# Clock Output Stop and Gating Controller

This block sits between a clock synthesiser and the output pins of a system clock generator. It takes four synthesised source clocks (CPU, PCI, reference and 48 MHz) and produces eleven gated outputs: two CPU clocks, one PCI clock that ignores the PCI stop, four stoppable PCI clocks, two reference clocks, a fixed 48 MHz clock and one output that carries 48 MHz or 24 MHz.

Three asynchronous active-low pins stop groups of outputs: a CPU stop, a PCI stop and a power-down. A per-output enable mask and a two-bit mode field add to them. Every stop request passes through a synchroniser clocked by the output's own source, and the gate register that applies it is updated on the falling edge. Outputs therefore park low only at the end of a complete high phase and restart with a complete high phase. A test mode replaces every source with a bypass clock, and a tri-state mode removes every output enable.

Top module: `clk_out_stop_ctrl`

## Requirements
- R1: While `rst_n` is low every `clk_out` bit is 0. After release, in mode 2'b00 with all stop pins high and all enable bits set, each output is high in the high phase and low in the low phase of its source, and `clk_oe` is all ones.
- R2: With `cpu_stop_n` low, outputs 0 and 1 are parked low and all other outputs keep running.
- R3: With `pci_stop_n` low, outputs 3 to 6 are parked low and output 2 keeps running.
- R4: With `pwr_dn_n` low, all eleven outputs, output 2 included, are parked low.
- R5: `en_mask[i]` controls `clk_out[i]`: 1 lets it run, 0 parks it low. Index map: 0-1 CPU, 2 free-running PCI, 3-6 stoppable PCI, 7-8 reference, 9 fixed 48 MHz, 10 selectable 48/24 MHz.
- R6: A stop request is sampled by two rising edges of the output's source and applied at the next falling edge. No high pulse on an output is ever shorter than the high phase of its source, even when stop pins toggle at arbitrary times.
- R7: When every stop on an output is removed, the output resumes within four source cycles, and its first high pulse is a full high phase.
- R8: Mode 2'b01 (test) replaces every source clock with `byp_clk`, and the stop pins and enable bits still gate the outputs.
- R9: Mode 2'b11 (tri-state) drives `clk_oe` to all zeros and parks every output low, regardless of the stop pins and enable bits.
- R10: Mode 2'b10 (spread-spectrum request) gates outputs exactly as mode 2'b00 does.
- R11: `sel24_strap` is captured on the first 48 MHz source edge after reset. When it is 1, output 10 runs at half the 48 MHz source rate; when it is 0, output 10 runs at the full rate. Later changes of the strap have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src_clk | input | 1 | Synthesised CPU clock |
| pci_src_clk | input | 1 | Synthesised PCI clock |
| ref_src_clk | input | 1 | Reference oscillator clock |
| usb_src_clk | input | 1 | Synthesised 48 MHz clock |
| byp_clk | input | 1 | Bypass clock used in test mode |
| cpu_stop_n | input | 1 | Asynchronous CPU stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down, active low |
| sel24_strap | input | 1 | Strap level selecting 24 MHz on output 10 |
| mode_i | input | 2 | 00 normal, 01 test, 10 spread request, 11 tri-state |
| en_mask | input | 11 | Per-output enable bits |
| clk_out | output | 11 | Gated clock outputs |
| clk_oe | output | 11 | Output enables, 0 means high impedance |

## Verification
The assertions treat each stop pin as a level that is settled around every rising edge of the clock that samples it, so the sampled values stand for what the synchroniser captures. They tolerate the extra edges that a mode change produces on the muxed clocks, because each property is clocked by the same muxed clock that drives its flops. The stimulus changes stop pins, enables and mode one nanosecond after a falling edge of the common source. The only exception is the runt test, where the CPU stop toggles at offsets chosen never to land on an edge. The strap is held steady across reset release until it has been captured.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'b00,
        MODE_TEST   = 2'b01,
        MODE_SPREAD = 2'b10,
        MODE_TRI    = 2'b11
    } out_mode_e;

    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic stop_i,
    output logic clk_o,
    output logic run_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  run_d, run_q;

    // Rising-edge synchroniser of the stop request
    always_comb begin
        sync_d      = sync_q;
        sync_d.sync = {sync_q.sync[SYNC_STAGES-2:0], stop_i};
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) sync_q <= '{sync: '1};
        else        sync_q <= sync_d;
    end

    // Gate register updated while the clock is low
    always_comb run_d = ~sync_q.sync[LAST];

    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

    assign clk_o = clk_i & run_q;
    assign run_o = run_q;

    assert_parked_when_stopped_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
        sync_q.sync[LAST] |-> !run_q);

    assert_restart_on_release_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(sync_q.sync[LAST]) |-> run_q);

endmodule

// File: rtl/clkstop_div.sv
module clkstop_div (
    input  logic clk_i,
    input  logic rst_n,
    input  logic strap_i,
    output logic clk_o
);
    typedef struct packed {
        logic half;
        logic sel;
        logic locked;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.half = ~st_q.half;
        if (!st_q.locked) begin
            st_d.sel    = strap_i;
            st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) st_q <= '{half: 1'b0, sel: 1'b0, locked: 1'b0};
        else        st_q <= st_d;
    end

    assign clk_o = st_q.sel ? st_q.half : clk_i;

    assert_strap_held_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
        st_q.locked |=> $stable(st_q.sel));

endmodule

// File: rtl/clk_out_stop_ctrl.sv
module clk_out_stop_ctrl
    import clkstop_pkg::*;
#(
    parameter  int N_CPU       = 2,
    parameter  int N_PCI_STOP  = 4,
    parameter  int N_REF       = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int N_OUT       = N_CPU + 1 + N_PCI_STOP + N_REF + 2
) (
    input  logic             rst_n,
    input  logic             cpu_src_clk,
    input  logic             pci_src_clk,
    input  logic             ref_src_clk,
    input  logic             usb_src_clk,
    input  logic             byp_clk,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    input  logic             sel24_strap,
    input  logic [1:0]       mode_i,
    input  logic [N_OUT-1:0] en_mask,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_oe
);
    localparam int IDX_PCIF = N_CPU;
    localparam int IDX_PCI0 = IDX_PCIF + 1;
    localparam int IDX_REF0 = IDX_PCI0 + N_PCI_STOP;
    localparam int IDX_48   = IDX_REF0 + N_REF;
    localparam int IDX_ALT  = IDX_48 + 1;

    logic test_w, tri_w, park_all_w;
    logic cpu_g, pci_g, ref_g, usb_g, alt_g;
    logic [N_OUT-1:0] src_w, grp_stop_w, stop_w, run_w;

    assign test_w     = (mode_i == MODE_TEST);
    assign tri_w      = (mode_i == MODE_TRI);
    assign park_all_w = ~pwr_dn_n | tri_w;

    // Test mode swaps every synthesised source for the bypass clock
    assign cpu_g = test_w ? byp_clk : cpu_src_clk;
    assign pci_g = test_w ? byp_clk : pci_src_clk;
    assign ref_g = test_w ? byp_clk : ref_src_clk;
    assign usb_g = test_w ? byp_clk : usb_src_clk;

    clkstop_div u_div (
        .clk_i   (usb_g),
        .rst_n   (rst_n),
        .strap_i (sel24_strap),
        .clk_o   (alt_g)
    );

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        if (i < N_CPU) begin : g_cpu
            assign src_w[i]      = cpu_g;
            assign grp_stop_w[i] = ~cpu_stop_n;
        end else if (i == IDX_PCIF) begin : g_pcif
            assign src_w[i]      = pci_g;
            assign grp_stop_w[i] = 1'b0;
        end else if (i < IDX_REF0) begin : g_pci
            assign src_w[i]      = pci_g;
            assign grp_stop_w[i] = ~pci_stop_n;
        end else if (i < IDX_48) begin : g_ref
            assign src_w[i]      = ref_g;
            assign grp_stop_w[i] = 1'b0;
        end else if (i == IDX_48) begin : g_usb
            assign src_w[i]      = usb_g;
            assign grp_stop_w[i] = 1'b0;
        end else begin : g_alt
            assign src_w[i]      = alt_g;
            assign grp_stop_w[i] = 1'b0;
        end

        assign stop_w[i] = grp_stop_w[i] | park_all_w | ~en_mask[i];

        clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_i  (src_w[i]),
            .rst_n  (rst_n),
            .stop_i (stop_w[i]),
            .clk_o  (clk_out[i]),
            .run_o  (run_w[i])
        );
    end

    assign clk_oe = {N_OUT{~tri_w}};

    initial assert (SYNC_STAGES >= MIN_SYNC_STAGES && IDX_ALT == N_OUT - 1);

    assert_cpu_stop_parks_R2: assert property (@(posedge cpu_g) disable iff (!rst_n)
        ($past(!cpu_stop_n, 2) && $past(!cpu_stop_n)) |-> !run_w[0]);

    assert_pwrdn_parks_free_pci_R4: assert property (@(posedge pci_g) disable iff (!rst_n)
        ($past(!pwr_dn_n, 2) && $past(!pwr_dn_n)) |-> !run_w[IDX_PCIF]);

endmodule

// File: tb/sim_clk_out_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clk_out_stop_ctrl;
    localparam int N = 11;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;
    logic byp;
    assign byp = ~clk;

    logic rst_n = 1'b0, cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic sel24 = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [N-1:0] en = '1;
    logic [N-1:0] out, oe;

    clk_out_stop_ctrl u0 (
        .rst_n(rst_n), .cpu_src_clk(clk), .pci_src_clk(clk), .ref_src_clk(clk),
        .usb_src_clk(clk), .byp_clk(byp), .cpu_stop_n(cpu_stop_n),
        .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n), .sel24_strap(sel24),
        .mode_i(mode), .en_mask(en), .clk_out(out), .clk_oe(oe)
    );

    typedef struct {
        logic [N-1:0] hi;
        logic [N-1:0] lo;
        logic [N-1:0] oe;
        string        tag;
    } exp_t;

    exp_t sbq[$];
    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check_val(string tag, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic set_in(logic cs, logic ps, logic pd, logic [1:0] m, logic [N-1:0] e);
        @(negedge clk); #1;
        cpu_stop_n = cs; pci_stop_n = ps; pwr_dn_n = pd; mode = m; en = e;
    endtask

    // Driver side: queue the expected high/low phase pattern
    task automatic expect_pat(logic [N-1:0] hi, logic [N-1:0] lo, logic [N-1:0] o, string tag);
        exp_t e;
        repeat (4) @(posedge clk);
        e.hi = hi; e.lo = lo; e.oe = o; e.tag = tag;
        sbq.push_back(e);
        repeat (2) @(posedge clk);
    endtask

    // Monitor: sample high phase, then low phase, compare against queue head
    initial forever begin
        exp_t e;
        logic [N-1:0] h, l, o;
        @(posedge clk); #1;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            h = out; o = oe;
            @(negedge clk); #1;
            l = out;
            checks++;
            if (h !== e.hi || l !== e.lo || o !== e.oe) begin
                fails++;
                $display("FAIL %s: hi=%b lo=%b oe=%b expected hi=%b lo=%b oe=%b",
                         e.tag, h, l, o, e.hi, e.lo, e.oe);
            end
        end
    end

    // Pulse width monitor on output 0
    realtime t_rise = 0.0;
    bit meas_en = 0;
    int pulses = 0, runts = 0;
    always @(posedge out[0]) t_rise = $realtime;
    always @(negedge out[0]) if (meas_en) begin
        pulses++;
        if (($realtime - t_rise) < 2.49 || ($realtime - t_rise) > 2.51) runts++;
    end

    // Edge counter on output 10
    bit cnt_en = 0;
    int edges = 0;
    always @(posedge out[10]) if (cnt_en) edges++;

    task automatic count_alt(string tag, int expv);
        @(posedge clk); #1;
        edges = 0; cnt_en = 1;
        repeat (16) @(posedge clk);
        #1; cnt_en = 0;
        check_val(tag, edges, expv);
    endtask

    localparam logic [N-1:0] ALL  = '1;
    localparam logic [N-1:0] NONE = '0;
    localparam logic [N-1:0] CPU  = 11'b000_0000_0011;
    localparam logic [N-1:0] PCIS = 11'b000_0111_1000;

    initial begin
        // R1: reset state
        repeat (2) @(posedge clk); #1;
        check_val("R1 outputs low in reset (high phase)", int'(out), 0);
        check_val("R1 oe all ones in normal mode", int'(oe), int'(ALL));
        @(negedge clk); #1; rst_n = 1'b1;
        expect_pat(ALL, NONE, ALL, "R1 all outputs run after reset");

        set_in(1'b0, 1'b1, 1'b1, 2'b00, ALL);
        expect_pat(ALL & ~CPU, NONE, ALL, "R2 cpu stop parks 0-1");
        set_in(1'b1, 1'b1, 1'b1, 2'b00, ALL);
        expect_pat(ALL, NONE, ALL, "R7 restart after cpu stop release");

        set_in(1'b1, 1'b0, 1'b1, 2'b00, ALL);
        expect_pat(ALL & ~PCIS, NONE, ALL, "R3 pci stop parks 3-6, 2 runs");
        set_in(1'b0, 1'b0, 1'b1, 2'b00, ALL);
        expect_pat(ALL & ~PCIS & ~CPU, NONE, ALL, "R2 R3 both stops");

        set_in(1'b1, 1'b1, 1'b0, 2'b00, ALL);
        expect_pat(NONE, NONE, ALL, "R4 power-down parks all");
        set_in(1'b1, 1'b1, 1'b1, 2'b00, ALL);
        expect_pat(ALL, NONE, ALL, "R7 restart after power-down");

        set_in(1'b1, 1'b1, 1'b1, 2'b00, 11'b101_0101_0101);
        expect_pat(11'b101_0101_0101, NONE, ALL, "R5 enable mask A");
        set_in(1'b1, 1'b1, 1'b1, 2'b00, 11'b010_1010_1010);
        expect_pat(11'b010_1010_1010, NONE, ALL, "R5 enable mask B");

        set_in(1'b1, 1'b1, 1'b1, 2'b10, ALL);
        expect_pat(ALL, NONE, ALL, "R10 spread mode gates as normal");
        set_in(1'b1, 1'b0, 1'b1, 2'b10, ALL);
        expect_pat(ALL & ~PCIS, NONE, ALL, "R10 spread mode honours pci stop");

        set_in(1'b1, 1'b1, 1'b1, 2'b01, ALL);
        expect_pat(NONE, ALL, ALL, "R8 test mode follows bypass clock");
        set_in(1'b0, 1'b1, 1'b1, 2'b01, ALL);
        expect_pat(NONE, ALL & ~CPU, ALL, "R8 test mode with cpu stop");

        set_in(1'b1, 1'b1, 1'b1, 2'b11, ALL);
        expect_pat(NONE, NONE, NONE, "R9 tri-state with all running");
        set_in(1'b0, 1'b0, 1'b0, 2'b11, NONE);
        expect_pat(NONE, NONE, NONE, "R9 tri-state with stops active");

        set_in(1'b1, 1'b1, 1'b1, 2'b00, ALL);
        expect_pat(ALL, NONE, ALL, "R7 back to normal");

        // R6 R7: asynchronous cpu stop toggling, no runt pulses
        @(negedge clk); #1;
        pulses = 0; runts = 0; meas_en = 1;
        #7.3  cpu_stop_n = ~cpu_stop_n;
        #11.1 cpu_stop_n = ~cpu_stop_n;
        #2.9  cpu_stop_n = ~cpu_stop_n;
        #13.7 cpu_stop_n = ~cpu_stop_n;
        #6.1  cpu_stop_n = ~cpu_stop_n;
        #9.3  cpu_stop_n = ~cpu_stop_n;
        #4.7  cpu_stop_n = ~cpu_stop_n;
        #12.9 cpu_stop_n = ~cpu_stop_n;
        repeat (8) @(posedge clk);
        @(negedge clk); #1; meas_en = 0;
        check_val("R6 no shortened pulse on output 0", runts, 0);
        check_val("R7 output 0 resumed pulsing", int'(pulses >= 5), 1);

        // R11: strap selection of output 10
        count_alt("R11 strap low gives full rate", 16);
        @(negedge clk); #1; rst_n = 1'b0; sel24 = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1;
        repeat (8) @(posedge clk);
        count_alt("R11 strap high gives half rate", 8);
        @(negedge clk); #1; sel24 = 1'b0;
        repeat (4) @(posedge clk);
        count_alt("R11 strap change after reset ignored", 8);

        repeat (4) @(posedge clk);
        check_val("R11 queue drained", sbq.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule